// File: doc/BRIEF.md
# Two-Wire Serial Slave Front End

This block is the bit-level front end of a slave device on a two-wire clocked serial bus. A bus master drives the clock line and both sides share one open-drain data line. The block brings both raw lines into the system clock domain and finds start and stop conditions. It checks the first byte of each transaction against the device's own address. It shifts write bytes in and read bytes out, most significant bit first, and drives the acknowledge bit in the ninth clock.

An upper-level controller sits behind the block and handles command meaning and storage. The block gives that controller one-cycle event pulses: start, stop, address hit with the transfer direction, received byte, read byte taken, and master not-acknowledge. The controller gives the block the byte to send next, a level that accepts or refuses each written byte, and a write-busy flag.

Start and stop detection is switched off in two cases: while the block is shifting out read data, and while the write-busy flag is high. In all other states, a start or a stop ends whatever input was in progress.

Top module: `tw_slave_front`

## Requirements
- R1: While rst_ni is low and after reset is released, sda_low_o is 0 and no event output pulses until the bus shows a start condition.
- R2: A falling SDA while SCL is high is a start condition. It pulses start_o and restarts address reception, even in the middle of a byte.
- R3: A rising SDA while SCL is high is a stop condition. It pulses stop_o and returns the block to idle. No byte is acknowledged after a stop until a new start is seen.
- R4: After reset, and before any start condition, clocked bytes are not acknowledged and raise no address hit and no rx_valid_o.
- R5: The first byte after a start is taken MSB first. Its upper seven bits are compared with dev_addr_i. On a match the block pulses addr_hit_o, sets rw_o to bit 0 (1 means read) and pulls SDA low in the ninth clock. On a mismatch the block does not acknowledge and ignores the bus until the next start or stop.
- R6: In a write, each following byte appears on rx_data_o with a one-cycle rx_valid_o pulse after its eighth SCL rising edge. The block acknowledges the byte if ack_i is high when SCL falls at the end of the eighth clock. Otherwise it does not acknowledge and ignores the bus until the next start or stop.
- R7: In a read, tx_data_i is taken on the SCL falling edge that ends an acknowledge slot, and tx_load_o pulses. The bits are driven MSB first, and each bit changes only after an SCL falling edge. SDA is released for the ninth clock.
- R8: If the master acknowledges a read byte (SDA low in the ninth clock), the next byte is loaded and sent. If the master does not acknowledge, rd_nack_o pulses, SDA stays released, and the block waits for a start or stop.
- R9: While the block is shifting out the eight bits of a read byte, start and stop conditions are ignored and the byte continues undisturbed.
- R10: While wr_busy_i is high, start and stop conditions are ignored and the block state does not change because of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| sda_low_o | output | 1 | 1 pulls the data line low; 0 releases it |
| dev_addr_i | input | DATA_W-1 | Own slave address |
| wr_busy_i | input | 1 | Write in progress; suppresses start/stop |
| ack_i | input | 1 | Accept the current write byte |
| tx_data_i | input | DATA_W | Next read byte |
| start_o | output | 1 | Start condition accepted (pulse) |
| stop_o | output | 1 | Stop condition accepted (pulse) |
| addr_hit_o | output | 1 | Own address matched (pulse) |
| rw_o | output | 1 | Direction of the current transfer, 1 = read |
| rx_valid_o | output | 1 | Write byte complete (pulse) |
| rx_data_o | output | DATA_W | Received byte, valid with rx_valid_o |
| tx_load_o | output | 1 | tx_data_i taken (pulse) |
| rd_nack_o | output | 1 | Master did not acknowledge a read byte (pulse) |

## Verification
A wrong state in this block first shows on the data line. The ninth-clock acknowledge may be missing, may appear where none should, or a read bit may be wrong. The master samples each of these in the same SCL high phase, within one bus bit of the fault. A wrong bit count or a misplaced shift corrupts the byte on rx_data_o or on the bus in the byte where it occurs. A condition that should have been suppressed but was accepted shows as an extra start_o or stop_o pulse. It also causes a lost acknowledge on the next byte, a few system clocks after the offending SDA edge.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_RX,
    ST_TX,
    ST_MACK,
    ST_WAIT
  } tw_state_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/tw_cond_det.sv
module tw_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // SDA edge with SCL high on both samples
  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/tw_shifter.sv
module tw_shifter #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              rx_i,
  input  logic              bit_i,
  input  logic              inc_i,
  input  logic              tx_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              full_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      data_o <= '0;
      cnt_o  <= '0;
    end else if (load_i) begin
      data_o <= load_data_i;
      cnt_o  <= '0;
    end else if (clr_i) begin
      cnt_o <= '0;
    end else if (rx_i) begin
      data_o <= {data_o[DATA_W-2:0], bit_i};
      cnt_o  <= cnt_o + 1'b1;
    end else begin
      if (inc_i) cnt_o  <= cnt_o + 1'b1;
      if (tx_i)  data_o <= {data_o[DATA_W-2:0], 1'b0};
    end

  assign full_o = (cnt_o == CNT_W'(DATA_W));
endmodule

// File: rtl/tw_slave_front.sv
module tw_slave_front
  import tw_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned ADDR_W     = DATA_W - 1,
  localparam int unsigned CNT_W      = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_low_o,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic              wr_busy_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              start_o,
  output logic              stop_o,
  output logic              addr_hit_o,
  output logic              rw_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              tx_load_o,
  output logic              rd_nack_o
);
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic sh_clr, sh_rx, sh_inc, sh_tx, sh_load, sh_full;
  logic [DATA_W-1:0] sh_data;
  logic [CNT_W-1:0]  sh_cnt;
  tw_state_e state_q, state_d;
  logic drive_q, drive_d, rw_q, rw_d, mack_q, mack_d;
  logic ev_start, ev_stop, ev_hit, ev_rx, ev_load, ev_nack;
  logic tx_active, cond_ok, addr_match;

  tw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({scl_i, sda_i}),
    .q_o ({scl_s, sda_s})
  );

  tw_cond_det u_det (
    .clk_i, .rst_ni,
    .scl_i      (scl_s),
    .sda_i      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  tw_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni,
    .clr_i       (sh_clr),
    .rx_i        (sh_rx),
    .bit_i       (sda_s),
    .inc_i       (sh_inc),
    .tx_i        (sh_tx),
    .load_i      (sh_load),
    .load_data_i (tx_data_i),
    .data_o      (sh_data),
    .cnt_o       (sh_cnt),
    .full_o      (sh_full)
  );

  assign tx_active  = (state_q == ST_TX);
  assign cond_ok    = ~tx_active & ~wr_busy_i;
  assign addr_match = (sh_data[DATA_W-1:1] == dev_addr_i);

  always_comb begin
    state_d  = state_q;
    drive_d  = drive_q;
    rw_d     = rw_q;
    mack_d   = mack_q;
    sh_clr   = 1'b0;
    sh_rx    = 1'b0;
    sh_inc   = 1'b0;
    sh_tx    = 1'b0;
    sh_load  = 1'b0;
    ev_start = 1'b0;
    ev_stop  = 1'b0;
    ev_hit   = 1'b0;
    ev_rx    = 1'b0;
    ev_load  = 1'b0;
    ev_nack  = 1'b0;
    if (start_det && cond_ok) begin
      state_d  = ST_ADDR;
      drive_d  = 1'b0;
      sh_clr   = 1'b1;
      ev_start = 1'b1;
    end else if (stop_det && cond_ok) begin
      state_d = ST_IDLE;
      drive_d = 1'b0;
      ev_stop = 1'b1;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise && !sh_full) sh_rx = 1'b1;
          else if (scl_fall && sh_full) begin
            if (addr_match) begin
              state_d = ST_ACK;
              drive_d = 1'b1;
              rw_d    = sh_data[0];
              ev_hit  = 1'b1;
            end else begin
              state_d = ST_WAIT;
            end
          end
        end
        ST_RX: begin
          if (scl_rise && !sh_full) begin
            sh_rx = 1'b1;
            ev_rx = (sh_cnt == CNT_W'(DATA_W - 1));
          end else if (scl_fall && sh_full) begin
            if (ack_i) begin
              state_d = ST_ACK;
              drive_d = 1'b1;
            end else begin
              state_d = ST_WAIT;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              sh_load = 1'b1;
              ev_load = 1'b1;
              drive_d = ~tx_data_i[DATA_W-1];
              state_d = ST_TX;
            end else begin
              sh_clr  = 1'b1;
              drive_d = 1'b0;
              state_d = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) sh_inc = 1'b1;
          else if (scl_fall) begin
            if (sh_full) begin
              drive_d = 1'b0;
              state_d = ST_MACK;
            end else begin
              sh_tx   = 1'b1;
              drive_d = ~sh_data[DATA_W-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) mack_d = ~sda_s;
          else if (scl_fall) begin
            if (mack_q) begin
              sh_load = 1'b1;
              ev_load = 1'b1;
              drive_d = ~tx_data_i[DATA_W-1];
              state_d = ST_TX;
            end else begin
              ev_nack = 1'b1;
              state_d = ST_WAIT;
            end
          end
        end
        ST_IDLE, ST_WAIT: ;
        default: begin
          state_d = ST_IDLE;
          drive_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      drive_q    <= 1'b0;
      rw_q       <= 1'b0;
      mack_q     <= 1'b0;
      start_o    <= 1'b0;
      stop_o     <= 1'b0;
      addr_hit_o <= 1'b0;
      rx_valid_o <= 1'b0;
      tx_load_o  <= 1'b0;
      rd_nack_o  <= 1'b0;
    end else begin
      state_q    <= state_d;
      drive_q    <= drive_d;
      rw_q       <= rw_d;
      mack_q     <= mack_d;
      start_o    <= ev_start;
      stop_o     <= ev_stop;
      addr_hit_o <= ev_hit;
      rx_valid_o <= ev_rx;
      tx_load_o  <= ev_load;
      rd_nack_o  <= ev_nack;
    end

  assign sda_low_o = drive_q;
  assign rw_o      = rw_q;
  assign rx_data_o = sh_data;
endmodule

// File: rtl/tw_slave_front_chk.sv
module tw_slave_front_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic wr_busy_i,
  input logic tx_active,
  input logic sda_low_o,
  input logic start_o,
  input logic stop_o,
  input logic addr_hit_o,
  input logic rx_valid_o,
  input logic tx_load_o,
  input logic rd_nack_o
);
  always @(negedge clk_i)
    if (!rst_ni)
      assert_reset_quiet_R1: assert (!sda_low_o && !start_o && !stop_o && !addr_hit_o
                                     && !rx_valid_o && !tx_load_o && !rd_nack_o);

  assert_cond_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o));

  assert_events_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_o, stop_o, addr_hit_o, rx_valid_o, tx_load_o, rd_nack_o}));

  assert_drive_scl_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_low_o) |-> !scl_i);

  assert_nack_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_nack_o |-> !sda_low_o);

  assert_tx_inhibit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_active |=> (!start_o && !stop_o));

  assert_busy_inhibit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_busy_i |=> (!start_o && !stop_o));
endmodule

bind tw_slave_front tw_slave_front_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_i      (scl_i),
  .wr_busy_i  (wr_busy_i),
  .tx_active  (tx_active),
  .sda_low_o  (sda_low_o),
  .start_o    (start_o),
  .stop_o     (stop_o),
  .addr_hit_o (addr_hit_o),
  .rx_valid_o (rx_valid_o),
  .tx_load_o  (tx_load_o),
  .rd_nack_o  (rd_nack_o)
);

// File: tb/tw_slave_front_test.sv
`timescale 1ns/1ps
module tw_slave_front_test;
  localparam int Q = 10;
  localparam logic [6:0] MY_ADDR = 7'h5A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, wr_busy = 1'b0, ack_en = 1'b1;
  logic [7:0] tx_base = 8'h00;
  logic sda_low, start_p, stop_p, hit_p, rw, rxv_p, load_p, nack_p;
  logic [7:0] rx_data, tx_data;
  wire sda_bus = sda_m & ~sda_low;

  int n_start = 0, n_stop = 0, n_hit = 0, n_rx = 0, n_load = 0, n_nack = 0;
  logic [7:0] last_rx = 8'h00;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign tx_data = tx_base + 8'(n_load);

  tw_slave_front uut (
    .clk_i (clk), .rst_ni (rst_n), .scl_i (scl), .sda_i (sda_bus), .sda_low_o (sda_low),
    .dev_addr_i (MY_ADDR), .wr_busy_i (wr_busy), .ack_i (ack_en), .tx_data_i (tx_data),
    .start_o (start_p), .stop_o (stop_p), .addr_hit_o (hit_p), .rw_o (rw),
    .rx_valid_o (rxv_p), .rx_data_o (rx_data), .tx_load_o (load_p), .rd_nack_o (nack_p)
  );

  always @(posedge clk) begin
    if (start_p) n_start <= n_start + 1;
    if (stop_p)  n_stop  <= n_stop + 1;
    if (hit_p)   n_hit   <= n_hit + 1;
    if (load_p)  n_load  <= n_load + 1;
    if (nack_p)  n_nack  <= n_nack + 1;
    if (rxv_p) begin
      n_rx    <= n_rx + 1;
      last_rx <= rx_data;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic scl_low();
    scl = 1'b0; tick(Q);
  endtask

  task automatic do_start();
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; tick(Q);
    scl = 1'b1; tick(2*Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    acked = sda_low;
    tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic recv_byte(input logic mack, input int glitch_idx, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      scl = 1'b1; tick(Q);
      b[7-i] = sda_bus;
      if (i == glitch_idx) begin
        tick(2); sda_m = 1'b0; tick(4); sda_m = 1'b1; tick(4);
      end else begin
        tick(Q);
      end
      scl = 1'b0;
    end
    tick(Q);
    sda_m = ~mack; tick(Q);
    scl = 1'b1;    tick(2*Q);
    scl = 1'b0;    tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1", "sda_low in reset", int'(sda_low), 0);
    rst_n = 1'b1;
    tick(20);
    chk("R1", "sda_low after reset", int'(sda_low), 0);
    chk("R1", "events after reset", n_start + n_stop + n_hit + n_rx + n_load + n_nack, 0);
  endtask

  task automatic t_no_start();
    logic a;
    scl_low();
    send_byte({MY_ADDR, 1'b0}, a);
    chk("R4", "ack without start", int'(a), 0);
    send_byte(8'h11, a);
    chk("R4", "hit/rx without start", n_hit + n_rx, 0);
    do_stop();
  endtask

  task automatic t_write();
    logic a;
    int s0 = n_start, p0 = n_stop, h0 = n_hit, r0 = n_rx;
    ack_en = 1'b1;
    do_start();
    chk("R2", "start pulse", n_start - s0, 1);
    send_byte({MY_ADDR, 1'b0}, a);
    chk("R5", "address ack", int'(a), 1);
    chk("R5", "addr hit", n_hit - h0, 1);
    chk("R5", "rw write", int'(rw), 0);
    send_byte(8'hA5, a);
    chk("R6", "data ack", int'(a), 1);
    chk("R6", "rx byte", int'(last_rx), 'hA5);
    send_byte(8'h3C, a);
    chk("R6", "second rx byte", int'(last_rx), 'h3C);
    chk("R6", "rx count", n_rx - r0, 2);
    do_stop();
    chk("R3", "stop pulse", n_stop - p0, 1);
  endtask

  task automatic t_addr_miss();
    logic a;
    int r0 = n_rx, h0 = n_hit;
    do_start();
    send_byte({MY_ADDR ^ 7'h01, 1'b0}, a);
    chk("R5", "wrong address ack", int'(a), 0);
    send_byte(8'h77, a);
    chk("R5", "byte after miss ack", int'(a), 0);
    chk("R5", "no hit/rx after miss", (n_rx - r0) + (n_hit - h0), 0);
    do_stop();
  endtask

  task automatic t_data_nack();
    logic a;
    int r0 = n_rx;
    do_start();
    send_byte({MY_ADDR, 1'b0}, a);
    ack_en = 1'b0;
    send_byte(8'h5E, a);
    chk("R6", "refused byte ack", int'(a), 0);
    chk("R6", "refused byte still presented", int'(last_rx), 'h5E);
    ack_en = 1'b1;
    send_byte(8'h12, a);
    chk("R6", "byte after refusal ack", int'(a), 0);
    chk("R6", "rx count after refusal", n_rx - r0, 1);
    do_stop();
  endtask

  task automatic t_restart_abort();
    logic a;
    int s0 = n_start, h0 = n_hit;
    do_start();
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
    do_start();
    chk("R2", "repeated start pulses", n_start - s0, 2);
    send_byte({MY_ADDR, 1'b0}, a);
    chk("R2", "address ack after abort", int'(a), 1);
    chk("R2", "hit after abort", n_hit - h0, 1);
    do_stop();
  endtask

  task automatic t_stop_mid();
    logic a;
    int p0 = n_stop, h0 = n_hit;
    do_start();
    send_byte({MY_ADDR, 1'b0}, a);
    bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
    do_stop();
    chk("R3", "stop mid byte", n_stop - p0, 1);
    scl_low();
    send_byte({MY_ADDR, 1'b0}, a);
    chk("R3", "ack after stop without start", int'(a), 0);
    chk("R3", "hits after stop", n_hit - h0, 1);
    do_stop();
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] b0, b1;
    int l0, n0 = n_nack, p0 = n_stop;
    tx_base = 8'h4D;
    l0 = n_load;
    do_start();
    send_byte({MY_ADDR, 1'b1}, a);
    chk("R5", "read address ack", int'(a), 1);
    chk("R5", "rw read", int'(rw), 1);
    recv_byte(1'b1, -1, b0);
    chk("R7", "first read byte", int'(b0), int'(8'(8'h4D + 8'(l0))));
    recv_byte(1'b0, -1, b1);
    chk("R8", "second read byte after master ack", int'(b1), int'(8'(8'h4D + 8'(l0 + 1))));
    chk("R8", "loads", n_load - l0, 2);
    chk("R8", "nack pulse", n_nack - n0, 1);
    tick(Q);
    chk("R8", "released after nack", int'(sda_low), 0);
    do_stop();
    chk("R8", "stop after nack", n_stop - p0, 1);
  endtask

  task automatic t_read_glitch();
    logic a;
    logic [7:0] b;
    int s0, p0;
    tx_base = 8'hB6 - 8'(n_load);
    do_start();
    send_byte({MY_ADDR, 1'b1}, a);
    s0 = n_start; p0 = n_stop;
    recv_byte(1'b0, 2, b);
    chk("R9", "byte through glitch", int'(b), 'hB6);
    chk("R9", "no start/stop during read", (n_start - s0) + (n_stop - p0), 0);
    do_stop();
  endtask

  task automatic t_busy();
    logic a;
    int s0 = n_start, p0 = n_stop, r0;
    wr_busy = 1'b1;
    do_start();
    chk("R10", "start while busy", n_start - s0, 0);
    send_byte({MY_ADDR, 1'b0}, a);
    chk("R10", "ack after ignored start", int'(a), 0);
    do_stop();
    wr_busy = 1'b0;
    do_start();
    send_byte({MY_ADDR, 1'b0}, a);
    chk("R10", "ack after busy cleared", int'(a), 1);
    r0 = n_rx;
    p0 = n_stop;
    wr_busy = 1'b1;
    do_stop();
    chk("R10", "stop while busy", n_stop - p0, 0);
    wr_busy = 1'b0;
    tick(Q);
    chk("R10", "no byte from ignored stop", n_rx - r0, 0);
    do_stop();
    chk("R3", "stop after busy", n_stop - p0, 1);
  endtask

  initial begin
    tick(5);
    t_reset();
    t_no_start();
    t_write();
    t_addr_miss();
    t_data_nack();
    t_restart_abort();
    t_stop_mid();
    t_read();
    t_read_glitch();
    t_busy();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule